// File: doc/BRIEF.md
# Split-Cache Victim Selection and Cross-Snoop Control

This block holds the tag state of a split instruction/data cache pair and decides what happens to each cache line. When a line is being filled, it names the way to overwrite. The instruction side evicts the line that has gone longest without being used. The data side evicts the line that was allocated earliest, and hits do not change that choice. When a data-side victim holds modified data, the block asks for a writeback of the old line in the same cycle as it reports the way it picked.

Each lookup that misses in one cache is also checked against the other cache at the same address. This catches code that rewrites itself. A hit found there becomes an invalidate command for that line. If the line is modified and sits in the data cache, the block first issues a writeback and then issues the invalidate on the next cycle.

Each accepted request gets one registered response in the cycle after it is accepted. The tag arrays are small register files inside the block. Data storage and bus sequencing are handled outside this block.

Top module: `split_repl_snoop`

## Requirements
- R1: The operation field is coded as 0 = instruction read, 1 = data read, 2 = data write, 3 = instruction fill, 4 = data fill. The address is {tag, set}, with the set index in the low bits. Every accepted request produces rsp_valid in the next cycle. For a lookup, rsp_hit and rsp_way give the hit way, and rsp_way reads 0 on a miss. A data write that hits marks the line modified.
- R2: A fill into a set that has an invalid way uses the lowest-numbered invalid way, whatever the replacement history of that set.
- R3: A fill into a full instruction set evicts the least-recently-used way. Both hits and fills count as uses.
- R4: A fill into a full data set evicts the way that was allocated least recently. Hits do not change this order.
- R5: When the data victim is valid and modified, the fill response carries wb_valid. wb_addr then holds {old tag, set}.
- R6: A data read or write that misses checks the instruction cache at the same address. On a hit, the response carries an invalidate for that instruction line (inv_icache = 1), and the line is removed.
- R7: An instruction read that misses checks the data cache. On a hit to a clean data line, the response carries an invalidate for that data line (inv_icache = 0) and no writeback.
- R8: If that data hit is modified, the response carries wb_valid with the line address and no invalidate. In the following cycle the block issues the data-side invalidate and clears the line, including its modified state. req_ready is low for exactly that cycle.
- R9: After reset, all lines are invalid, rsp_valid, wb_valid and inv_valid are low, and req_ready is high.
- R10: A request presented while req_ready is low is ignored. It produces no response and changes no tag state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Operation code (see R1) |
| req_addr | input | TAG_W+log2(SETS) | Line address {tag, set} |
| req_ready | output | 1 | Low while a snoop invalidate is pending |
| rsp_valid | output | 1 | Response for the request accepted in the previous cycle |
| rsp_hit | output | 1 | Lookup hit in the addressed cache |
| rsp_way | output | log2(WAYS) | Hit way or chosen fill way |
| wb_valid | output | 1 | Writeback of a modified data line requested |
| wb_addr | output | TAG_W+log2(SETS) | Address of the line to write back |
| inv_valid | output | 1 | Invalidate command |
| inv_icache | output | 1 | 1 = instruction cache line, 0 = data cache line |
| inv_set | output | log2(SETS) | Set of the invalidated line |
| inv_way | output | log2(WAYS) | Way of the invalidated line |

## Verification
The hardest case to reach is a modified data line that is hit by a snoop from the instruction side. Getting there takes a data fill, then a data write hit to the same line, then an instruction read miss to that address. Only then does the two-cycle writeback-then-invalidate sequence start. The stimulus also presents a request during the one cycle when req_ready is low. It then re-reads and re-fills the set to show that the line, its modified state and the ignored request all left no trace.

// File: rtl/xsnp_pkg.sv
package xsnp_pkg;
  typedef enum logic [2:0] {
    OP_IC_READ  = 3'd0,
    OP_DC_READ  = 3'd1,
    OP_DC_WRITE = 3'd2,
    OP_IC_FILL  = 3'd3,
    OP_DC_FILL  = 3'd4
  } op_e;
endpackage

// File: rtl/xsnp_tag_store.sv
module xsnp_tag_store #(
  parameter int SETS    = 4,
  parameter int WAYS    = 4,
  parameter int TAG_W   = 8,
  parameter bit HAS_MOD = 1'b1,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [IDX_W-1:0]            rd_set,
  input  logic [TAG_W-1:0]            lk_tag,
  output logic                        hit,
  output logic [WAY_W-1:0]            hit_way,
  output logic [WAYS-1:0]             rd_valid,
  output logic [WAYS-1:0]             rd_mod,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_tags,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_set,
  input  logic [WAY_W-1:0]            wr_way,
  input  logic [TAG_W-1:0]            wr_tag,
  input  logic                        mset_en,
  input  logic [IDX_W-1:0]            mset_set,
  input  logic [WAY_W-1:0]            mset_way,
  input  logic                        clr_en,
  input  logic [IDX_W-1:0]            clr_set,
  input  logic [WAY_W-1:0]            clr_way
);
  logic [TAG_W-1:0]           tag_mem [SETS][WAYS];
  logic [SETS-1:0][WAYS-1:0]  valid_q;
  logic [SETS-1:0][WAYS-1:0]  mod_q;

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_set][wr_way] <= wr_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      if (wr_en)  valid_q[wr_set][wr_way]   <= 1'b1;
      if (clr_en) valid_q[clr_set][clr_way] <= 1'b0;
    end
  end

  generate
    if (HAS_MOD) begin : g_mod
      always_ff @(posedge clk) begin
        if (rst) begin
          mod_q <= '0;
        end else begin
          if (wr_en)   mod_q[wr_set][wr_way]     <= 1'b0;
          if (mset_en) mod_q[mset_set][mset_way] <= 1'b1;
          if (clr_en)  mod_q[clr_set][clr_way]   <= 1'b0;
        end
      end
      for (genvar s = 0; s < SETS; s++) begin : g_s
        for (genvar w = 0; w < WAYS; w++) begin : g_w
          // R1
          mod_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
            mod_q[s][w] |-> valid_q[s][w]);
        end
      end
    end else begin : g_nomod
      assign mod_q = '0;
    end
  endgenerate

  always_comb begin
    rd_valid = valid_q[rd_set];
    rd_mod   = mod_q[rd_set];
    for (int w = 0; w < WAYS; w++) rd_tags[w] = tag_mem[rd_set][w];
  end

  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!hit && rd_valid[w] && (rd_tags[w] == lk_tag)) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/xsnp_age_order.sv
module xsnp_age_order #(
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [IDX_W-1:0] rd_set,
  output logic [WAY_W-1:0] old_way
);
  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  logic [WAY_W-1:0]          age_q [SETS][WAYS];
  logic [SETS-1:0][WAYS-1:0] oldest_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age_q[touch_set][w] <= '0;
        else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
          age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
      end
    end
  end

  always_comb begin
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++)
        oldest_vec[s][w] = (age_q[s][w] == OLDEST);
  end

  always_comb begin
    old_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (oldest_vec[rd_set][w]) old_way = WAY_W'(w);
  end

  generate
    for (genvar s = 0; s < SETS; s++) begin : g_chk
      // R3
      single_oldest_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(oldest_vec[s]) == 1);
    end
  endgenerate
endmodule

// File: rtl/split_repl_snoop.sv
module split_repl_snoop #(
  parameter int SETS    = 4,
  parameter int WAYS    = 4,
  parameter int TAG_W   = 8,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic              inv_valid,
  output logic              inv_icache,
  output logic [IDX_W-1:0]  inv_set,
  output logic [WAY_W-1:0]  inv_way
);
  import xsnp_pkg::*;

  function automatic logic [WAY_W-1:0] pick_way(input logic [WAYS-1:0] vld,
                                                input logic [WAY_W-1:0] fallback);
    logic             found;
    logic [WAY_W-1:0] way;
    found = 1'b0;
    way   = fallback;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !vld[w]) begin
        found = 1'b1;
        way   = WAY_W'(w);
      end
    end
    return way;
  endfunction

  op_e              op;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tg;
  logic             go;
  logic             pend_q;
  logic [IDX_W-1:0] pend_set;
  logic [WAY_W-1:0] pend_way;

  assign op        = op_e'(req_op);
  assign idx       = req_addr[IDX_W-1:0];
  assign tg        = req_addr[ADDR_W-1:IDX_W];
  assign req_ready = !pend_q;
  assign go        = req_valid && !pend_q;

  // instruction side
  logic                       ic_hit, ic_wr, ic_touch, ic_clr;
  logic [WAY_W-1:0]           ic_hit_way, ic_lru, ic_fill_way, ic_touch_way;
  logic [WAYS-1:0]            ic_valid, ic_mod;
  logic [WAYS-1:0][TAG_W-1:0] ic_tags;

  // data side
  logic                       dc_hit, dc_wr, dc_touch, dc_mset, dc_snp_clr, dc_clr;
  logic [WAY_W-1:0]           dc_hit_way, dc_lra, dc_fill_way, dc_clr_way;
  logic [IDX_W-1:0]           dc_clr_set;
  logic [WAYS-1:0]            dc_valid, dc_mod;
  logic [WAYS-1:0][TAG_W-1:0] dc_tags;

  xsnp_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .HAS_MOD(1'b0)) u_ic_tags (
    .clk(clk), .rst(rst), .rd_set(idx), .lk_tag(tg),
    .hit(ic_hit), .hit_way(ic_hit_way), .rd_valid(ic_valid), .rd_mod(ic_mod), .rd_tags(ic_tags),
    .wr_en(ic_wr), .wr_set(idx), .wr_way(ic_fill_way), .wr_tag(tg),
    .mset_en(1'b0), .mset_set(idx), .mset_way(ic_hit_way),
    .clr_en(ic_clr), .clr_set(idx), .clr_way(ic_hit_way));

  xsnp_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .HAS_MOD(1'b1)) u_dc_tags (
    .clk(clk), .rst(rst), .rd_set(idx), .lk_tag(tg),
    .hit(dc_hit), .hit_way(dc_hit_way), .rd_valid(dc_valid), .rd_mod(dc_mod), .rd_tags(dc_tags),
    .wr_en(dc_wr), .wr_set(idx), .wr_way(dc_fill_way), .wr_tag(tg),
    .mset_en(dc_mset), .mset_set(idx), .mset_way(dc_hit_way),
    .clr_en(dc_clr), .clr_set(dc_clr_set), .clr_way(dc_clr_way));

  xsnp_age_order #(.SETS(SETS), .WAYS(WAYS)) u_ic_lru (
    .clk(clk), .rst(rst), .touch_en(ic_touch), .touch_set(idx), .touch_way(ic_touch_way),
    .rd_set(idx), .old_way(ic_lru));

  xsnp_age_order #(.SETS(SETS), .WAYS(WAYS)) u_dc_lra (
    .clk(clk), .rst(rst), .touch_en(dc_touch), .touch_set(idx), .touch_way(dc_fill_way),
    .rd_set(idx), .old_way(dc_lra));

  assign ic_fill_way = pick_way(ic_valid, ic_lru);
  assign dc_fill_way = pick_way(dc_valid, dc_lra);
  assign dc_clr      = pend_q || dc_snp_clr;
  assign dc_clr_set  = pend_q ? pend_set : idx;
  assign dc_clr_way  = pend_q ? pend_way : dc_hit_way;

  logic              n_hit, n_wb, n_inv, n_inv_ic, n_pend;
  logic [WAY_W-1:0]  n_way, n_inv_way;
  logic [ADDR_W-1:0] n_wb_addr;

  always_comb begin
    ic_wr = 1'b0; ic_touch = 1'b0; ic_touch_way = ic_hit_way; ic_clr = 1'b0;
    dc_wr = 1'b0; dc_touch = 1'b0; dc_mset = 1'b0; dc_snp_clr = 1'b0;
    n_hit = 1'b0; n_way = '0; n_wb = 1'b0; n_wb_addr = '0;
    n_inv = 1'b0; n_inv_ic = 1'b0; n_inv_way = '0; n_pend = 1'b0;
    if (go) begin
      case (op)
        OP_IC_READ: begin
          n_hit = ic_hit;
          if (ic_hit) begin
            n_way    = ic_hit_way;
            ic_touch = 1'b1;
          end else if (dc_hit) begin
            if (dc_mod[dc_hit_way]) begin
              n_wb      = 1'b1;
              n_wb_addr = {dc_tags[dc_hit_way], idx};
              n_pend    = 1'b1;
            end else begin
              dc_snp_clr = 1'b1;
              n_inv      = 1'b1;
              n_inv_way  = dc_hit_way;
            end
          end
        end
        OP_DC_READ, OP_DC_WRITE: begin
          n_hit = dc_hit;
          if (dc_hit) begin
            n_way   = dc_hit_way;
            dc_mset = (op == OP_DC_WRITE);
          end else if (ic_hit) begin
            ic_clr    = 1'b1;
            n_inv     = 1'b1;
            n_inv_ic  = 1'b1;
            n_inv_way = ic_hit_way;
          end
        end
        OP_IC_FILL: begin
          n_way        = ic_fill_way;
          ic_wr        = 1'b1;
          ic_touch     = 1'b1;
          ic_touch_way = ic_fill_way;
        end
        OP_DC_FILL: begin
          n_way    = dc_fill_way;
          dc_wr    = 1'b1;
          dc_touch = 1'b1;
          if (dc_valid[dc_fill_way] && dc_mod[dc_fill_way]) begin
            n_wb      = 1'b1;
            n_wb_addr = {dc_tags[dc_fill_way], idx};
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_way    <= '0;
      wb_valid   <= 1'b0;
      wb_addr    <= '0;
      inv_valid  <= 1'b0;
      inv_icache <= 1'b0;
      inv_set    <= '0;
      inv_way    <= '0;
      pend_q     <= 1'b0;
      pend_set   <= '0;
      pend_way   <= '0;
    end else begin
      rsp_valid <= go;
      rsp_hit   <= n_hit;
      rsp_way   <= n_way;
      wb_valid  <= n_wb;
      wb_addr   <= n_wb_addr;
      pend_q    <= n_pend;
      if (n_pend) begin
        pend_set <= idx;
        pend_way <= dc_hit_way;
      end
      if (pend_q) begin
        inv_valid  <= 1'b1;
        inv_icache <= 1'b0;
        inv_set    <= pend_set;
        inv_way    <= pend_way;
      end else begin
        inv_valid  <= n_inv;
        inv_icache <= n_inv_ic;
        inv_set    <= idx;
        inv_way    <= n_inv_way;
      end
    end
  end

  // R8
  late_inv_chk: assert property (@(posedge clk) disable iff (rst)
    pend_q |=> (inv_valid && !inv_icache && !rsp_valid));
  // R5
  wb_in_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (rsp_valid && !rsp_hit && !inv_valid));
  // R6
  ic_inv_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (inv_valid && inv_icache) |-> (rsp_valid && !rsp_hit));
  // R10
  stall_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    !req_ready |=> req_ready);
endmodule

// File: tb/split_repl_snoop_tb.sv
`timescale 1ns/1ps
module split_repl_snoop_tb;
  localparam int SETS = 4, WAYS = 4, TAG_W = 8;
  localparam int ADDR_W = TAG_W + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_hit, wb_valid, inv_valid, inv_icache;
  logic [1:0] rsp_way, inv_set, inv_way;
  logic [ADDR_W-1:0] wb_addr;

  always #10 clk = ~clk;

  split_repl_snoop #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .inv_valid(inv_valid), .inv_icache(inv_icache),
    .inv_set(inv_set), .inv_way(inv_way));

  typedef struct {
    logic        hit;
    logic [1:0]  way;
    logic        wb;
    logic [9:0]  wba;
    logic        inv;
    logic        inv_ic;
    logic [1:0]  iset;
    logic [1:0]  iway;
    logic        late;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, fails = 0;
  bit done = 0;
  bit late_pend = 0;
  logic [1:0] late_set, late_way;

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic exp_t mk(input logic hit, input logic [1:0] way, input logic wb,
                              input logic [9:0] wba, input logic inv, input logic inv_ic,
                              input logic [1:0] iset, input logic [1:0] iway,
                              input logic late, input string req);
    exp_t e;
    e.hit = hit; e.way = way; e.wb = wb; e.wba = wba; e.inv = inv; e.inv_ic = inv_ic;
    e.iset = iset; e.iway = iway; e.late = late; e.req = req;
    return e;
  endfunction

  // driver: presents one request and queues its expected response
  task automatic send(input logic [2:0] op, input logic [7:0] tag, input logic [1:0] set, input exp_t e);
    req_valid = 1'b1;
    req_op    = op;
    req_addr  = {tag, set};
    exp_q.push_back(e);
    @(posedge clk); #2;
    req_valid = 1'b0;
  endtask

  task automatic send_ignored(input logic [2:0] op, input logic [7:0] tag, input logic [1:0] set);
    req_valid = 1'b1;
    req_op    = op;
    req_addr  = {tag, set};
    @(posedge clk); #2;
    req_valid = 1'b0;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10 request during stall produced a response", rsp_valid, 0);
  endtask

  // monitor: pops the scoreboard as responses appear
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (late_pend) begin
        chk(inv_valid && !inv_icache && inv_set == late_set && inv_way == late_way,
            "R8 delayed data invalidate", {inv_valid, inv_icache, inv_set, inv_way},
            {1'b1, 1'b0, late_set, late_way});
        chk(req_ready == 1'b1, "R10 ready back after stall", req_ready, 1);
        late_pend = 0;
      end
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10 unexpected response", 1, 0);
        end else begin
          exp_t e;
          logic [19:0] act, ex;
          e = exp_q.pop_front();
          act = {rsp_hit, rsp_way, wb_valid, wb_addr & {10{wb_valid}}, inv_valid,
                 inv_icache & inv_valid, inv_set & {2{inv_valid}}, inv_way & {2{inv_valid}}};
          ex  = {e.hit, e.way, e.wb, e.wba & {10{e.wb}}, e.inv,
                 e.inv_ic & e.inv, e.iset & {2{e.inv}}, e.iway & {2{e.inv}}};
          chk(act == ex, e.req, act, ex);
          if (e.late) begin
            chk(req_ready == 1'b0, "R8 ready low during pending invalidate", req_ready, 0);
            late_pend = 1;
            late_set  = e.iset;
            late_way  = e.iway;
          end
        end
      end
    end
  end

  localparam logic [2:0] ICR = 3'd0, DCR = 3'd1, DCW = 3'd2, ICF = 3'd3, DCF = 3'd4;

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    chk(!rsp_valid && !wb_valid && !inv_valid && req_ready, "R9 reset outputs",
        {rsp_valid, wb_valid, inv_valid, req_ready}, 4'b0001);
    @(posedge clk); #2;

    // instruction side, set 1
    send(ICF, 8'h10, 2'd1, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 ic fill way0"));
    send(ICF, 8'h11, 2'd1, mk(0, 1, 0, 0, 0, 0, 0, 0, 0, "R2 ic fill way1"));
    send(ICF, 8'h12, 2'd1, mk(0, 2, 0, 0, 0, 0, 0, 0, 0, "R2 ic fill way2"));
    send(ICF, 8'h13, 2'd1, mk(0, 3, 0, 0, 0, 0, 0, 0, 0, "R2 ic fill way3"));
    send(ICR, 8'h10, 2'd1, mk(1, 0, 0, 0, 0, 0, 0, 0, 0, "R1 ic read hit way0"));
    send(ICF, 8'h14, 2'd1, mk(0, 1, 0, 0, 0, 0, 0, 0, 0, "R3 lru victim way1"));
    send(ICR, 8'h11, 2'd1, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 evicted line misses"));
    send(ICF, 8'h15, 2'd1, mk(0, 2, 0, 0, 0, 0, 0, 0, 0, "R3 next lru victim way2"));
    send(ICR, 8'h15, 2'd1, mk(1, 2, 0, 0, 0, 0, 0, 0, 0, "R1 ic read hit way2"));

    // data side, set 2
    send(DCF, 8'h20, 2'd2, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 dc fill way0"));
    send(DCF, 8'h21, 2'd2, mk(0, 1, 0, 0, 0, 0, 0, 0, 0, "R2 dc fill way1"));
    send(DCF, 8'h22, 2'd2, mk(0, 2, 0, 0, 0, 0, 0, 0, 0, "R2 dc fill way2"));
    send(DCF, 8'h23, 2'd2, mk(0, 3, 0, 0, 0, 0, 0, 0, 0, "R2 dc fill way3"));
    send(DCR, 8'h20, 2'd2, mk(1, 0, 0, 0, 0, 0, 0, 0, 0, "R1 dc read hit way0"));
    send(DCW, 8'h21, 2'd2, mk(1, 1, 0, 0, 0, 0, 0, 0, 0, "R1 dc write hit way1"));
    send(DCF, 8'h24, 2'd2, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, "R4 oldest allocation way0 despite hit"));
    send(DCF, 8'h25, 2'd2, mk(0, 1, 1, {8'h21, 2'd2}, 0, 0, 0, 0, 0, "R5 modified victim writeback"));
    send(DCR, 8'h21, 2'd2, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, "R4 replaced data line misses"));

    // data miss snoops instruction side, set 3
    send(ICF, 8'h30, 2'd3, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 ic fill set3"));
    send(DCR, 8'h30, 2'd3, mk(0, 0, 0, 0, 1, 1, 3, 0, 0, "R6 dc read miss invalidates ic"));
    send(ICR, 8'h30, 2'd3, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 ic line removed"));
    send(ICF, 8'h31, 2'd3, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 ic refill lowest invalid"));
    send(DCW, 8'h31, 2'd3, mk(0, 0, 0, 0, 1, 1, 3, 0, 0, "R6 dc write miss invalidates ic"));

    // instruction miss snoops data side, set 0
    send(DCF, 8'h40, 2'd0, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 dc fill set0"));
    send(ICR, 8'h40, 2'd0, mk(0, 0, 0, 0, 1, 0, 0, 0, 0, "R7 clean dc snoop invalidate"));
    send(DCR, 8'h40, 2'd0, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, "R7 clean dc line removed"));
    send(DCF, 8'h41, 2'd0, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 dc refill lowest invalid"));
    send(DCW, 8'h41, 2'd0, mk(1, 0, 0, 0, 0, 0, 0, 0, 0, "R1 dc write hit marks modified"));
    send(ICR, 8'h41, 2'd0, mk(0, 0, 1, {8'h41, 2'd0}, 0, 0, 0, 0, 1, "R8 modified snoop writeback first"));
    send_ignored(DCF, 8'h42, 2'd0);
    send(DCR, 8'h41, 2'd0, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 modified line invalidated"));
    send(DCR, 8'h42, 2'd0, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 ignored fill left no line"));
    send(DCF, 8'h43, 2'd0, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 refill way0 without writeback"));

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all responses received", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule